// File: doc/BRIEF.md
# Strobed Bus Command Capture

This block sits on the device side of an asynchronous parallel memory bus. It samples the chip-enable, write-enable, output-enable and address-valid strobes on a fast internal clock. It recognises write cycles from those strobes and captures one address/data pair per cycle. Each capture is handed to the command logic inside the device as a single-clock pulse.

The address comes from one of two places. If address-valid was pulsed low before the write, the address is the one present when address-valid went high again. Otherwise it is the address present at the first rising edge of write-enable or chip-enable. The data is always taken at that first rising strobe edge.

A small sequence matcher follows the captured writes. It moves the operating mode from read to program or erase. Any write that does not fit the sequence sends it back to read mode.

Top module: `bus_cmd_capture`

## Requirements
- R1: After a synchronous reset, `mode` is read (encoding 0) and `cap_valid` is low.
- R2: A write-enable-controlled cycle is a capture. In this cycle CE# and WE# are low with OE# high, and WE# then rises first. `cap_valid` pulses 3 clock edges after that rising edge.
- R3: A chip-enable-controlled cycle is a capture. In this cycle WE# is low, CE# pulses low with OE# high, and CE# rises first. `cap_valid` pulses 3 clock edges after that rising edge.
- R4: A strobe pulse made while OE# is low produces no capture.
- R5: If address-valid was pulsed low before the write, `cap_addr` is the bus address present when address-valid rose. Address changes after that have no effect.
- R6: If address-valid was not pulsed, `cap_addr` is the bus address at the first rising write strobe. Changes before the second strobe rises are ignored.
- R7: `cap_data` is the bus data at the first rising write strobe. Data changes before the second strobe rises are ignored.
- R8: Each write cycle yields exactly one single-clock `cap_valid` pulse. `cap_addr` and `cap_data` hold their values between pulses.
- R9: The captured address is passed through unmodified whatever the state of the sequence matcher.
- R10: Three writes in a row select a mode: (0x555, 0xAA), then (0x2AA, 0x55), then data 0xA0 for program (`mode`=1) or data 0x80 for erase (`mode`=2). `mode` updates one clock after the `cap_valid` of the last write.
- R11: A write that breaks an expected step returns `mode` to read. In program mode, the next write is taken as the payload and also returns `mode` to read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_adv_n | input | 1 | Address valid, active low |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus write data |
| cap_valid | output | 1 | One-clock pulse per captured write |
| cap_addr | output | AW | Captured address |
| cap_data | output | DW | Captured data |
| mode | output | 2 | Operating mode: 0 read, 1 program, 2 erase |

## Verification
Writes are driven in the write-enable style and in the chip-enable style, each with and without an address-valid pulse. After the first strobe rises, the address and data are changed to junk before the second strobe rises. This tells which edge or source each value was taken from. A write with OE# low must produce nothing. Full program and erase sequences, a payload write, and a broken sequence from erase mode check the mode moves and the unchanged pass-through of the address.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } step_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/bus_write_decode.sv
module bus_write_decode #(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          ce_q, we_q, adv_q;
  logic          in_cycle;
  logic          adv_hit;
  logic [AW-1:0] adv_addr;
  logic          ce_rise, we_rise, adv_rise, complete;

  assign ce_rise  = ce_n && !ce_q;
  assign we_rise  = we_n && !we_q;
  assign adv_rise = adv_n && !adv_q;
  assign complete = in_cycle && oe_n && (ce_rise || we_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b1;
      we_q     <= 1'b1;
      adv_q    <= 1'b1;
      in_cycle <= 1'b0;
      adv_hit  <= 1'b0;
      adv_addr <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      ce_q     <= ce_n;
      we_q     <= we_n;
      adv_q    <= adv_n;
      wr_valid <= 1'b0;
      if (complete) begin
        wr_valid <= 1'b1;
        wr_addr  <= adv_hit ? adv_addr : addr;
        wr_data  <= data;
        adv_hit  <= 1'b0;
        in_cycle <= 1'b0;
      end else begin
        if (adv_rise) begin
          adv_hit  <= 1'b1;
          adv_addr <= addr;
        end
        if (!oe_n)
          in_cycle <= 1'b0;
        else if (!ce_n && !we_n)
          in_cycle <= 1'b1;
      end
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  a_r8_outputs_held: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));

  a_r2_valid_after_cycle: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(in_cycle));
endmodule

// File: rtl/bus_seq_match.sv
module bus_seq_match
  import bus_cmd_pkg::*;
#(
  parameter int          AW        = 23,
  parameter int          DW        = 16,
  parameter logic [AW-1:0] KEY_A1  = 'h555,
  parameter logic [DW-1:0] KEY_D1  = 'hAA,
  parameter logic [AW-1:0] KEY_A2  = 'h2AA,
  parameter logic [DW-1:0] KEY_D2  = 'h55,
  parameter logic [DW-1:0] OP_PROG = 'hA0,
  parameter logic [DW-1:0] OP_ERASE = 'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output mode_e         mode
);
  step_e step;
  logic  hit1, hit2;

  assign hit1 = (wr_addr == KEY_A1) && (wr_data == KEY_D1);
  assign hit2 = (wr_addr == KEY_A2) && (wr_data == KEY_D2);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_READ;
      step <= STEP_IDLE;
    end else if (wr_valid) begin
      if (mode == MODE_PROG && step == STEP_IDLE) begin
        mode <= MODE_READ;
      end else begin
        case (step)
          STEP_IDLE: begin
            if (hit1) step <= STEP_ONE;
            else      mode <= MODE_READ;
          end
          STEP_ONE: begin
            if (hit2) step <= STEP_TWO;
            else begin
              step <= STEP_IDLE;
              mode <= MODE_READ;
            end
          end
          default: begin
            step <= STEP_IDLE;
            if (wr_data == OP_PROG)       mode <= MODE_PROG;
            else if (wr_data == OP_ERASE) mode <= MODE_ERASE;
            else                          mode <= MODE_READ;
          end
        endcase
      end
    end
  end

  a_r1_reset_read: assert property (@(posedge clk)
    $past(rst) |-> (mode == MODE_READ));

  a_r10_mode_needs_write: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(mode));
endmodule

// File: rtl/bus_cmd_capture.sv
module bus_cmd_capture
  import bus_cmd_pkg::*;
#(
  parameter int AW          = 23,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic          bus_adv_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data,
  output logic [1:0]    mode
);
  localparam int PW = AW + DW;

  logic [3:0]    strb_s;
  logic [PW-1:0] path_s;
  mode_e         mode_q;

  bus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync_strb (
    .clk  (clk),
    .rst  (rst),
    .din  ({bus_ce_n, bus_we_n, bus_oe_n, bus_adv_n}),
    .dout (strb_s)
  );

  bus_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_path (
    .clk  (clk),
    .rst  (rst),
    .din  ({bus_addr, bus_data}),
    .dout (path_s)
  );

  bus_write_decode #(.AW(AW), .DW(DW)) u_decode (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (strb_s[3]),
    .we_n     (strb_s[2]),
    .oe_n     (strb_s[1]),
    .adv_n    (strb_s[0]),
    .addr     (path_s[PW-1:DW]),
    .data     (path_s[DW-1:0]),
    .wr_valid (cap_valid),
    .wr_addr  (cap_addr),
    .wr_data  (cap_data)
  );

  bus_seq_match #(.AW(AW), .DW(DW)) u_match (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (cap_valid),
    .wr_addr  (cap_addr),
    .wr_data  (cap_data),
    .mode     (mode_q)
  );

  assign mode = mode_q;
endmodule

// File: tb/bus_cmd_capture_tb.sv
module bus_cmd_capture_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
  logic [22:0] addr = '0;
  logic [15:0] data = '0;
  logic        cap_valid;
  logic [22:0] cap_addr;
  logic [15:0] cap_data;
  logic [1:0]  mode;

  int checks = 0, failures = 0;
  int cyc = 0, pulses = 0, last_cyc = 0, rise_cyc = 0;
  logic [22:0] last_a;
  logic [15:0] last_d;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_capture u_dut (
    .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_adv_n(adv_n), .bus_addr(addr), .bus_data(data),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_data(cap_data), .mode(mode)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && cap_valid) begin
      pulses++;
      last_cyc = cyc;
      last_a = cap_addr;
      last_d = cap_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus write; ce_style picks which strobe pulses, use_adv adds an address-valid pulse.
  task automatic bus_write(input bit ce_style, input bit use_adv, input bit oe_low,
                           input logic [22:0] a, input logic [15:0] d, input string tag);
    int p0;
    p0 = pulses;
    addr = a;
    data = d;
    if (use_adv) begin
      adv_n = 1'b0; idle(2);
      adv_n = 1'b1; idle(2);
      addr = ~a;
    end
    oe_n = !oe_low;
    if (ce_style) begin
      we_n = 1'b0; idle(2);
      ce_n = 1'b0; idle(3);
      ce_n = 1'b1;
    end else begin
      ce_n = 1'b0; idle(2);
      we_n = 1'b0; idle(3);
      we_n = 1'b1;
    end
    rise_cyc = cyc;
    idle(1);
    addr = a ^ 23'h1F0F0F;
    data = ~d;
    idle(2);
    ce_n = 1'b1;
    we_n = 1'b1;
    idle(8);
    oe_n = 1'b1;
    if (oe_low) begin
      chk({tag, " no capture with OE low"}, pulses - p0, 0);
    end else begin
      chk({tag, " pulse count (R8)"}, pulses - p0, 1);
      chk({tag, " address"}, last_a, a);
      chk({tag, " data (R7)"}, last_d, d);
      chk({tag, " latency"}, last_cyc - rise_cyc, 3);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(3);
    rst = 1'b0; idle(1);
    chk("R1 cap_valid after reset", cap_valid, 0);
    chk("R1 mode after reset", mode, 0);
  endtask

  task automatic t_styles();
    bus_write(1'b0, 1'b0, 1'b0, 23'h12345, 16'hBEEF, "R2 R6 WE style");
    bus_write(1'b1, 1'b0, 1'b0, 23'h6ABCD, 16'h1234, "R3 R6 CE style");
    bus_write(1'b0, 1'b1, 1'b0, 23'h00F0F, 16'hCAFE, "R5 WE with adv");
    bus_write(1'b1, 1'b1, 1'b0, 23'h7FFFF, 16'h0001, "R5 CE with adv");
    chk("R8 cap_addr held between pulses", cap_addr, 23'h7FFFF);
  endtask

  task automatic t_oe_low();
    bus_write(1'b0, 1'b0, 1'b1, 23'h00111, 16'h2222, "R4 WE");
    bus_write(1'b1, 1'b0, 1'b1, 23'h00333, 16'h4444, "R4 CE");
  endtask

  task automatic t_program();
    bus_write(1'b0, 1'b0, 1'b0, 23'h555, 16'h00AA, "R9 step1");
    bus_write(1'b1, 1'b1, 1'b0, 23'h2AA, 16'h0055, "R9 step2");
    bus_write(1'b0, 1'b0, 1'b0, 23'h40000, 16'h00A0, "R10 prog cmd");
    chk("R10 mode program", mode, 1);
    bus_write(1'b0, 1'b0, 1'b0, 23'h01234, 16'h5A5A, "R11 payload");
    chk("R11 payload returns to read", mode, 0);
  endtask

  task automatic t_erase_break();
    bus_write(1'b0, 1'b0, 1'b0, 23'h555, 16'h00AA, "R10 e1");
    bus_write(1'b0, 1'b0, 1'b0, 23'h2AA, 16'h0055, "R10 e2");
    bus_write(1'b1, 1'b0, 1'b0, 23'h00000, 16'h0080, "R10 erase cmd");
    chk("R10 mode erase", mode, 2);
    bus_write(1'b0, 1'b0, 1'b0, 23'h555, 16'h00AA, "R11 restart");
    chk("R11 mode kept while step valid", mode, 2);
    bus_write(1'b0, 1'b0, 1'b0, 23'h2AB, 16'h0055, "R11 wrong step");
    chk("R11 broken sequence to read", mode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(1);
    t_reset();
    t_styles();
    t_oe_low();
    t_program();
    t_erase_break();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule